// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block decides when an LCD panel's supply enable and its interface outputs (data, shift clock, sync) are allowed to run. Software selects the panel state through a two-bit mode field: only the value 11b requests the panel on, and every other value requests power save. A hardware sleep input overrides the field and forces the powered-down state whenever it is high.

The spacing between switching the interface signals and switching the supply is measured in display frames, counted from a single-cycle frame-start strobe supplied by the timing generator. On the way up, the signal gate opens first and the supply enable follows 127 frames later. On the way down, the supply enable drops first and the signals are forced low 127 frames later. The same sequence runs after reset, after mode programming, and on entry to or exit from power save. A request that reverses direction mid-sequence restarts the frame count and heads toward the new target without toggling either output twice.

Top module: `lcd_power_seq`

## Requirements
- R1: During and directly after reset, panelPowerEn, panelSigEn and panelReady are all 0.
- R2: While modeSel is 00b, 01b or 10b and the panel is off, no number of frame strobes changes any output.
- R3: In the clock cycle after modeSel = 11b (with hwSleep low) is first sampled from the off state, panelSigEn is 1 and panelPowerEn is still 0.
- R4: After power-up starts, panelPowerEn rises in the cycle after the 127th sampled frameStart pulse, and not earlier.
- R5: The frame count advances only on cycles where frameStart is 1; idle cycles between strobes, however many, do not shorten the delay.
- R6: When the panel is fully on and the request goes away, panelPowerEn drops in the next cycle while panelSigEn stays 1; panelSigEn drops in the cycle after the 127th following strobe. panelPowerEn is never 1 while panelSigEn is 0.
- R7: hwSleep = 1 blocks power-up even with modeSel = 11b, and from the on state it runs the same power-down sequence; releasing it runs the power-up sequence.
- R8: A reversed request during either ramp restarts the count: the outputs do not change at the reversal, and the new end state is reached after 127 strobes counted from the reversal.
- R9: panelReady is 1 exactly when panelPowerEn and panelSigEn are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Panel mode field; 11b requests on, any other value power save |
| hwSleep | input | 1 | Hardware power-save request, forces power-down when 1 |
| frameStart | input | 1 | Single-cycle pulse at the start of each display frame |
| panelPowerEn | output | 1 | Panel supply enable |
| panelSigEn | output | 1 | Signal gate; 0 holds data, shift clock and sync low |
| panelReady | output | 1 | Panel fully on |

## Verification
A wrong sequencer state appears at the ports within one cycle, because every output is decoded straight from the state register: a skipped ramp shows as the supply rising together with the gate, and a missed reversal shows as the gate closing while the panel is still requested. A wrong frame count is only visible at the end of a ramp, so the bench counts exactly 126 strobes with idle gaps, checks nothing has moved, and then expects the change on the 127th; reversals at mid-ramp expose a counter that fails to restart because the end state would then arrive early.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    ST_OFF       = 2'd0,
    ST_RAMP_UP   = 2'd1,
    ST_ON        = 2'd2,
    ST_RAMP_DOWN = 2'd3
  } seqState_t;

  // strobes from control to the frame counter
  typedef struct packed {
    logic clear;
    logic advance;
  } cntCmd_t;

  localparam logic [1:0] MODE_ACTIVE = 2'b11;

endpackage

// File: rtl/pps_frame_counter.sv
module pps_frame_counter
  import pps_pkg::*;
#(
  parameter int FRAME_DELAY = 127,
  parameter int CNT_W       = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cntCmd,
  input  logic    frameStart,
  output logic    lastFrame
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(FRAME_DELAY - 1);

  logic [CNT_W-1:0] frameCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (cntCmd.clear) begin
      frameCnt <= '0;
    end else if (cntCmd.advance) begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  assign lastFrame = (frameCnt == LAST_VAL);

  // R5: count holds on every cycle without an advance or clear
  a_r5_hold_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!cntCmd.advance && !cntCmd.clear) |=> $stable(frameCnt));

  // R5: an advance is only ever requested on a strobe cycle
  a_r5_advance_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    cntCmd.advance |-> frameStart);

  // R4: the counter never wraps past its terminal value
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    lastFrame |-> !cntCmd.advance);

endmodule

// File: rtl/pps_seq_ctrl.sv
module pps_seq_ctrl
  import pps_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    targetOn,
  input  logic    frameStart,
  input  logic    lastFrame,
  output cntCmd_t cntCmd,
  output logic    powerEn,
  output logic    gateOpen
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cntCmd    = '0;
    unique case (state)
      ST_OFF: begin
        if (targetOn) begin
          nextState    = ST_RAMP_UP;
          cntCmd.clear = 1'b1;
        end
      end
      ST_RAMP_UP: begin
        if (!targetOn) begin
          nextState    = ST_RAMP_DOWN;
          cntCmd.clear = 1'b1;
        end else if (frameStart) begin
          if (lastFrame) begin
            nextState    = ST_ON;
            cntCmd.clear = 1'b1;
          end else begin
            cntCmd.advance = 1'b1;
          end
        end
      end
      ST_ON: begin
        if (!targetOn) begin
          nextState    = ST_RAMP_DOWN;
          cntCmd.clear = 1'b1;
        end
      end
      ST_RAMP_DOWN: begin
        if (targetOn) begin
          nextState    = ST_RAMP_UP;
          cntCmd.clear = 1'b1;
        end else if (frameStart) begin
          if (lastFrame) begin
            nextState    = ST_OFF;
            cntCmd.clear = 1'b1;
          end else begin
            cntCmd.advance = 1'b1;
          end
        end
      end
      default: nextState = ST_OFF;
    endcase
  end

  assign powerEn  = (state == ST_ON);
  assign gateOpen = (state != ST_OFF);

  // R3: gate opens only in answer to an on request
  a_r3_gate_on_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOpen) |-> $past(targetOn));

  // R4: supply rises only at a strobe while still requested
  a_r4_rise_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerEn) |-> ($past(frameStart) && $past(targetOn)));

  // R6: supply drops the cycle after the request goes away
  a_r6_power_drop: assert property (@(posedge clk) disable iff (!rstN)
    (powerEn && !targetOn) |=> !powerEn);

  // R6/R8: gate closes only at a strobe with no on request pending
  a_r8_gate_close: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOpen) |-> ($past(frameStart) && !$past(targetOn)));

  // R2: an off panel stays off without a request
  a_r2_stay_off: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOpen && !targetOn) |=> !gateOpen);

endmodule

// File: rtl/lcd_power_seq.sv
module lcd_power_seq
  import pps_pkg::*;
#(
  parameter int FRAME_DELAY = 127
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       hwSleep,
  input  logic       frameStart,
  output logic       panelPowerEn,
  output logic       panelSigEn,
  output logic       panelReady
);

  localparam int CNT_W = (FRAME_DELAY > 2) ? $clog2(FRAME_DELAY) : 1;

  logic    targetOn;
  logic    lastFrame;
  cntCmd_t cntCmd;

  assign targetOn = (modeSel == MODE_ACTIVE) && !hwSleep;

  pps_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .targetOn   (targetOn),
    .frameStart (frameStart),
    .lastFrame  (lastFrame),
    .cntCmd     (cntCmd),
    .powerEn    (panelPowerEn),
    .gateOpen   (panelSigEn)
  );

  pps_frame_counter #(
    .FRAME_DELAY (FRAME_DELAY),
    .CNT_W       (CNT_W)
  ) cnt_i (
    .clk        (clk),
    .rstN       (rstN),
    .cntCmd     (cntCmd),
    .frameStart (frameStart),
    .lastFrame  (lastFrame)
  );

  assign panelReady = panelPowerEn & panelSigEn;

  // R6: supply never on while the signals are gated low
  a_r6_power_needs_gate: assert property (@(posedge clk) disable iff (!rstN)
    panelPowerEn |-> panelSigEn);

  // R9: ready implies both enables on
  a_r9_ready_both_on: assert property (@(posedge clk) disable iff (!rstN)
    panelReady |-> (panelPowerEn && panelSigEn));

  // R7: hardware sleep never lets the supply come up
  a_r7_sleep_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (hwSleep && !panelPowerEn) |=> !panelPowerEn);

endmodule

// File: tb/lcd_power_seq_tb_top.sv
module lcd_power_seq_tb_top;

  localparam int DELAY = 127;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       hwSleep = 1'b0;
  logic       frameStart = 1'b0;
  logic       panelPowerEn, panelSigEn, panelReady;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  expPow;
    logic  expSig;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #5 clk = ~clk;

  lcd_power_seq #(.FRAME_DELAY(DELAY)) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .modeSel      (modeSel),
    .hwSleep      (hwSleep),
    .frameStart   (frameStart),
    .panelPowerEn (panelPowerEn),
    .panelSigEn   (panelSigEn),
    .panelReady   (panelReady)
  );

  task automatic compare(input string tag, input logic pw, input logic sg,
                         input logic rd);
    checks++;
    if (panelPowerEn !== pw || panelSigEn !== sg || panelReady !== rd) begin
      failures++;
      $display("FAIL %s: pow/sig/rdy actual=%b%b%b expected=%b%b%b",
               tag, panelPowerEn, panelSigEn, panelReady, pw, sg, rd);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic [1:0] m, input logic hw, input logic fs,
                      input logic eP, input logic eG, input string tag);
    expItem_t it;
    @(negedge clk);
    modeSel = m;
    hwSleep = hw;
    frameStart = fs;
    it.expPow = eP;
    it.expSig = eG;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // n strobes, each followed by gapLen idle cycles
  task automatic frames(input int n, input int gapLen, input logic [1:0] m,
                        input logic hw, input logic eP, input logic eG,
                        input string tag);
    for (int i = 0; i < n; i++) begin
      step(m, hw, 1'b1, eP, eG, tag);
      for (int g = 0; g < gapLen; g++) step(m, hw, 1'b0, eP, eG, tag);
    end
  endtask

  // monitor: compare every queued item just after the edge that makes it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        compare(it.tag, it.expPow, it.expSig, it.expPow & it.expSig);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compare("R1 in reset", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 1'b0, 1'b0, 1'b0);

    // R2: non-active mode values leave the panel off
    frames(DELAY + 3, 1, 2'b00, 1'b0, 1'b0, 1'b0, "R2 mode 00");
    frames(DELAY + 3, 0, 2'b01, 1'b0, 1'b0, 1'b0, "R2 mode 01");
    frames(DELAY + 3, 1, 2'b10, 1'b0, 1'b0, 1'b0, "R2 mode 10");

    // R3: gate opens first; R4/R5: 127 strobes with idle gaps
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, "R3 gate opens first");
    for (int g = 0; g < 20; g++)
      step(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, "R5 idle no advance");
    frames(DELAY - 1, 2, 2'b11, 1'b0, 1'b0, 1'b1, "R4 before 127th");
    step(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, "R4 R9 on at 127th");
    step(2'b11, 1'b0, 1'b0, 1'b1, 1'b1, "R9 held on");

    // R6: supply first, signals 127 strobes later
    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, "R6 supply drops first");
    frames(DELAY - 1, 1, 2'b00, 1'b0, 1'b0, 1'b1, "R6 gate held");
    step(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, "R6 gate closes at 127th");

    // R7: hardware sleep blocks, releases, and powers down
    frames(DELAY + 3, 1, 2'b11, 1'b1, 1'b0, 1'b0, "R7 sleep blocks up");
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, "R7 release starts up");
    frames(DELAY - 1, 0, 2'b11, 1'b0, 1'b0, 1'b1, "R7 ramp up");
    step(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, "R7 on after release");
    step(2'b11, 1'b1, 1'b0, 1'b0, 1'b1, "R7 sleep drops supply");
    frames(DELAY - 1, 1, 2'b11, 1'b1, 1'b0, 1'b1, "R7 ramp down");
    step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, "R7 gate closes");

    // R8: reverse during ramp up
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, "R8 up start");
    frames(60, 1, 2'b11, 1'b0, 1'b0, 1'b1, "R8 partial up");
    step(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, "R8 reversal no glitch");
    frames(DELAY - 1, 1, 2'b01, 1'b0, 1'b0, 1'b1, "R8 restarted down");
    step(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R8 down done");

    // R8: reverse during ramp down
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, "R8 up again");
    frames(DELAY - 1, 0, 2'b11, 1'b0, 1'b0, 1'b1, "R8 ramp up");
    step(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, "R8 on");
    step(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, "R8 down begins");
    frames(50, 1, 2'b10, 1'b0, 1'b0, 1'b1, "R8 partial down");
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, "R8 reversal to up");
    frames(DELAY - 1, 1, 2'b11, 1'b0, 1'b0, 1'b1, "R8 restarted up");
    step(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, "R8 R9 up done");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule